// File: doc/BRIEF.md
# Internal Register Space Decoder

This block sits between the execute stage of an 8-bit microcontroller core and the storage behind its 256-location internal register space. Each request carries an address, a flag telling whether the address came from an instruction field (direct) or from a working register (indirect), read and write strobes and write data. The block decides where the access lands and returns read data through one mux.

The lower half of the space (00h–7Fh) is scratchpad RAM whatever the addressing mode. The upper half is shared by two stores. Indirect accesses reach the upper 128 bytes of a 256-byte scratchpad held inside the block. Direct accesses go out on a special-function-register bus, which has room for up to 128 registers. RAM reads and SFR reads both return one cycle after the request. A direct read of an SFR location with no register behind it returns zero and raises a flag for that cycle.

Top module: `regspace_decoder`

## Requirements
- R1: A request to 00h–7Fh reaches scratchpad RAM in both direct and indirect mode. A byte written in one mode reads back in the other.
- R2: An indirect request to 80h–FFh reaches the upper scratchpad RAM and raises neither `sfr_rd` nor `sfr_wr`.
- R3: A direct write to 80h–FFh leaves scratchpad RAM unchanged. The same address read indirectly afterwards returns the old byte.
- R4: A direct write to 80h–FFh drives `sfr_wr` high for exactly the next cycle. In that cycle `sfr_addr` equals the request address and `sfr_wdata` equals the request data.
- R5: A read request gives `rd_valid` high in the following cycle and low in the request cycle. For a direct upper read, `sfr_rd` is high in that following cycle and `rd_data` equals `sfr_rdata` when `sfr_hit` is high.
- R6: A direct upper read answered with `sfr_hit` low gives `rd_data` = 00h and `rd_unmapped` high in the response cycle. The flag is low again in the cycle after.
- R7: A request with `req_rd` and `req_wr` both high is a write only. `rd_valid` and `sfr_rd` stay low in the next cycle, and the byte is stored.
- R8: Reset drives `rd_valid`, `rd_unmapped`, `sfr_rd` and `sfr_wr` low, even when a request is held at the inputs. Reset keeps the RAM contents.
- R9: A request to 00h–7Fh never raises `sfr_rd` or `sfr_wr`.
- R10: A RAM write takes effect at the clock edge where `req_wr` is high. A read request in the next cycle returns the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_addr | input | ADDR_W | Register space address |
| req_ind | input | 1 | 1 = indirect addressing, 0 = direct |
| req_rd | input | 1 | Read request |
| req_wr | input | 1 | Write request (wins over read) |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | DATA_W | Read data (00h when not valid) |
| rd_unmapped | output | 1 | Direct read hit no SFR |
| sfr_addr | output | ADDR_W | SFR bus address |
| sfr_rd | output | 1 | SFR read strobe |
| sfr_wr | output | 1 | SFR write strobe |
| sfr_wdata | output | DATA_W | SFR write data |
| sfr_rdata | input | DATA_W | SFR read data, same cycle as `sfr_rd` |
| sfr_hit | input | 1 | An SFR answers at `sfr_addr` |

## Verification
A wrong routing decision shows in the cycle after the request. A stray or missing `sfr_rd`/`sfr_wr` pulse appears there, or a wrong `rd_data` when the location is read back. A RAM byte corrupted by a direct upper write stays hidden until an indirect read of that address, so the tests pair every steering case with a readback through the other mode. A response-stage register that survives reset, or one held for too long, shows as a strobe or unmapped flag one cycle late.

// File: rtl/regspace_decoder.sv
module regspace_decoder #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_ind,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_unmapped,
  output logic [ADDR_W-1:0] sfr_addr,
  output logic              sfr_rd,
  output logic              sfr_wr,
  output logic [DATA_W-1:0] sfr_wdata,
  input  logic [DATA_W-1:0] sfr_rdata,
  input  logic              sfr_hit
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] ram_q;

  wire to_sfr  = req_addr[ADDR_W-1] & ~req_ind;
  wire do_wr   = req_wr;
  wire do_rd   = req_rd & ~req_wr;

  always_ff @(posedge clk) begin
    if (rst_n && do_wr && !to_sfr) mem[req_addr] <= req_wdata;
    if (do_rd && !to_sfr) ram_q <= mem[req_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      sfr_rd    <= 1'b0;
      sfr_wr    <= 1'b0;
      sfr_addr  <= '0;
      sfr_wdata <= '0;
    end else begin
      rd_valid <= do_rd;
      sfr_rd   <= do_rd & to_sfr;
      sfr_wr   <= do_wr & to_sfr;
      if (to_sfr && (do_rd || do_wr)) begin
        sfr_addr  <= req_addr;
        sfr_wdata <= req_wdata;
      end
    end
  end

  assign rd_unmapped = sfr_rd & ~sfr_hit;
  assign rd_data = !rd_valid ? '0 :
                   sfr_rd    ? (sfr_hit ? sfr_rdata : '0) :
                               ram_q;
endmodule

// File: rtl/regspace_decoder_chk.sv
module regspace_decoder_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_ind,
  input logic              req_rd,
  input logic              req_wr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_unmapped,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic              sfr_rd,
  input logic              sfr_wr,
  input logic [DATA_W-1:0] sfr_wdata,
  input logic              sfr_hit
);
  wire up_dir = req_addr[ADDR_W-1] & ~req_ind;

  a_r2_no_sfr_when_indirect: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_rd || req_wr) && req_ind) |=> (!sfr_rd && !sfr_wr));

  a_r9_no_sfr_when_lower: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_rd || req_wr) && !req_addr[ADDR_W-1]) |=> (!sfr_rd && !sfr_wr));

  a_r4_sfr_write_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && up_dir) |=> (sfr_wr && sfr_addr == $past(req_addr) && sfr_wdata == $past(req_wdata)));

  a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sfr_rd && sfr_wr));

  a_r5_read_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && !req_wr) |=> rd_valid);

  a_r5_sfr_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && !req_wr && up_dir) |=> (sfr_rd && sfr_addr == $past(req_addr)));

  a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |-> (rd_valid && sfr_rd && !sfr_hit && rd_data == '0));

  a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && req_wr) |=> (!rd_valid && !sfr_rd));
endmodule

bind regspace_decoder regspace_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk (
  .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_ind(req_ind),
  .req_rd(req_rd), .req_wr(req_wr), .req_wdata(req_wdata),
  .rd_valid(rd_valid), .rd_data(rd_data), .rd_unmapped(rd_unmapped),
  .sfr_addr(sfr_addr), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
  .sfr_wdata(sfr_wdata), .sfr_hit(sfr_hit)
);

// File: tb/tb_regspace_decoder.sv
module tb_regspace_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_addr = '0;
  logic       req_ind = 1'b0, req_rd = 1'b0, req_wr = 1'b0;
  logic [7:0] req_wdata = '0;
  logic       rd_valid, rd_unmapped, sfr_rd, sfr_wr, sfr_hit;
  logic [7:0] rd_data, sfr_addr, sfr_wdata, sfr_rdata;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  regspace_decoder dut (
    .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_ind(req_ind),
    .req_rd(req_rd), .req_wr(req_wr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_unmapped(rd_unmapped),
    .sfr_addr(sfr_addr), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .sfr_hit(sfr_hit)
  );

  // SFR model: registers exist at 80h-9Fh, value = address ^ 5Ah
  always_comb begin
    sfr_hit   = (sfr_addr >= 8'h80) && (sfr_addr <= 8'h9F);
    sfr_rdata = sfr_hit ? (sfr_addr ^ 8'h5A) : 8'hFF;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one request cycle; returns at the negedge after the capturing edge
  task automatic issue(input logic [7:0] a, input logic ind, input logic rd,
                       input logic wr, input logic [7:0] wd);
    @(negedge clk);
    req_addr = a; req_ind = ind; req_rd = rd; req_wr = wr; req_wdata = wd;
    @(negedge clk);
    req_rd = 1'b0; req_wr = 1'b0;
  endtask

  task automatic t_reset_state();
    check(!rd_valid && !rd_unmapped && !sfr_rd && !sfr_wr, "R8 reset outputs",
          {rd_valid, rd_unmapped, sfr_rd, sfr_wr}, 0);
  endtask

  task automatic t_lower_both_modes();
    issue(8'h10, 1'b0, 1'b0, 1'b1, 8'hA5);
    check(!sfr_wr && !sfr_rd, "R9 lower direct write no SFR strobe", sfr_wr, 0);
    issue(8'h10, 1'b1, 1'b1, 1'b0, 8'h00);
    check(rd_valid && rd_data == 8'hA5, "R1 direct write, indirect read", rd_data, 8'hA5);
    check(!sfr_rd, "R9 lower read no SFR strobe", sfr_rd, 0);
    issue(8'h7F, 1'b1, 1'b0, 1'b1, 8'h3C);
    issue(8'h7F, 1'b0, 1'b1, 1'b0, 8'h00);
    check(rd_data == 8'h3C, "R1 indirect write, direct read at 7Fh", rd_data, 8'h3C);
    issue(8'h7F, 1'b0, 1'b0, 1'b1, 8'hC7);
    issue(8'h7F, 1'b0, 1'b1, 1'b0, 8'h00);
    check(rd_data == 8'hC7, "R10 overwrite visible next read", rd_data, 8'hC7);
  endtask

  task automatic t_upper_indirect();
    issue(8'h90, 1'b1, 1'b0, 1'b1, 8'h77);
    check(!sfr_wr, "R2 indirect upper write no sfr_wr", sfr_wr, 0);
    issue(8'hFF, 1'b1, 1'b0, 1'b1, 8'h5E);
    issue(8'h90, 1'b1, 1'b1, 1'b0, 8'h00);
    check(rd_valid && rd_data == 8'h77 && !sfr_rd, "R2 indirect upper read 90h", rd_data, 8'h77);
    issue(8'hFF, 1'b1, 1'b1, 1'b0, 8'h00);
    check(rd_data == 8'h5E, "R2 indirect upper read FFh", rd_data, 8'h5E);
  endtask

  task automatic t_direct_upper();
    issue(8'h90, 1'b0, 1'b0, 1'b1, 8'hEE);
    check(sfr_wr && sfr_addr == 8'h90 && sfr_wdata == 8'hEE, "R4 SFR write fields",
          {sfr_wr, sfr_addr, sfr_wdata}, {1'b1, 8'h90, 8'hEE});
    @(negedge clk);
    check(!sfr_wr, "R4 sfr_wr one cycle only", sfr_wr, 0);
    issue(8'h90, 1'b1, 1'b1, 1'b0, 8'h00);
    check(rd_data == 8'h77, "R3 RAM untouched by direct upper write", rd_data, 8'h77);
    @(negedge clk);
    req_addr = 8'h85; req_ind = 1'b0; req_rd = 1'b1;
    #1;
    check(!rd_valid, "R5 no valid in request cycle", rd_valid, 0);
    @(negedge clk);
    req_rd = 1'b0;
    check(rd_valid && sfr_rd && sfr_addr == 8'h85, "R5 SFR read strobe next cycle",
          {rd_valid, sfr_rd, sfr_addr}, {1'b1, 1'b1, 8'h85});
    check(rd_data == (8'h85 ^ 8'h5A) && !rd_unmapped, "R5 SFR read data", rd_data, 8'h85 ^ 8'h5A);
  endtask

  task automatic t_unmapped();
    issue(8'hF0, 1'b0, 1'b1, 1'b0, 8'h00);
    check(rd_unmapped && rd_valid && rd_data == 8'h00, "R6 unmapped read zero and flag",
          {rd_unmapped, rd_data}, {1'b1, 8'h00});
    @(negedge clk);
    check(!rd_unmapped, "R6 flag drops after one cycle", rd_unmapped, 0);
  endtask

  task automatic t_read_write_both();
    issue(8'h20, 1'b1, 1'b1, 1'b1, 8'h11);
    check(!rd_valid && !sfr_rd, "R7 rd+wr gives no read", {rd_valid, sfr_rd}, 0);
    issue(8'h20, 1'b1, 1'b1, 1'b0, 8'h00);
    check(rd_data == 8'h11, "R7 rd+wr stored byte", rd_data, 8'h11);
    issue(8'h88, 1'b0, 1'b1, 1'b1, 8'h42);
    check(sfr_wr && !sfr_rd && !rd_valid, "R7 direct upper rd+wr is SFR write",
          {sfr_wr, sfr_rd, rd_valid}, 3'b100);
  endtask

  task automatic t_reset_keeps_ram();
    issue(8'h30, 1'b0, 1'b0, 1'b1, 8'hC3);
    @(negedge clk);
    req_addr = 8'hF0; req_ind = 1'b0; req_rd = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(!rd_valid && !rd_unmapped && !sfr_rd && !sfr_wr, "R8 strobes held low in reset",
          {rd_valid, rd_unmapped, sfr_rd, sfr_wr}, 0);
    req_rd = 1'b0;
    rst_n = 1'b1;
    issue(8'h30, 1'b1, 1'b1, 1'b0, 8'h00);
    check(rd_data == 8'hC3, "R8 RAM kept across reset", rd_data, 8'hC3);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        t_lower_both_modes();
        t_upper_indirect();
        t_direct_upper();
        t_unmapped();
        t_read_write_both();
        t_reset_keeps_ram();
      end
      begin
        repeat (5000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule